// File: doc/BRIEF.md
# Dual-Source Interrupt Down-Counter

This block generates a CPU interrupt request from an 8-bit programmable down-counter that is clocked from one of two sources. In line mode, each pulse for a visible video line with rendering enabled moves the counter down by one. In cycle mode, a prescaler divides the CPU clock enable by four and each prescaler wrap moves the counter down by one. Software uses four register writes: one loads a latch, one arms the counter and selects the mode, one enables the interrupt, and one disables and acknowledges it.

The counter is signed. It stops at -1 and does not wrap. The interrupt fires on the step from 0 to -1. A reload-pending flag decides whether the latch, enable and acknowledge writes also copy the latch into the counter. The arm write sets this flag. In line mode, every line pulse clears it, and an interrupt that fires sets it again. The request is a level that stays high until software acknowledges it.

Top module: `irq_down_timer`

## Requirements
- R1: After reset, the request is low, the interrupt is disabled, line mode is selected, the latch, the counter and the prescaler phase are zero, and the reload-pending flag is clear. So enabling the interrupt and then sending one counted line raises the request.
- R2: A write whose masked address (address AND 0xF003) equals 0xC000 stores data into the latch. The counter is also loaded with the new value only when reload-pending is set.
- R3: A write that decodes to 0xC001 sets reload-pending and loads the counter from the latch. Data bit 0 selects the mode: 1 selects cycle mode and 0 selects line mode.
- R4: A write that decodes to 0xE000 disables the interrupt and drops the request on the next cycle. The counter is reloaded from the latch when reload-pending is set.
- R5: A write that decodes to 0xE001 enables the interrupt. The counter is reloaded from the latch when reload-pending is set.
- R6: In cycle mode, every fourth asserted CPU clock enable produces one counter step, and line pulses have no effect.
- R7: In line mode, a step happens only on a line pulse whose line number is 0 to 239 while rendering is enabled. The CPU clock enable has no effect in this mode.
- R8: In line mode, every line pulse clears reload-pending. This includes lines outside 0 to 239 and lines with rendering off. An interrupt that fires in line mode sets reload-pending again.
- R9: A step decrements the counter only when it is not negative. The interrupt fires on the step from 0 to -1 if the interrupt is enabled. The counter stays at -1 until a reload.
- R10: The request is a level. Once raised, it stays high until an acknowledge write. A step from 0 to -1 while the interrupt is disabled raises nothing.
- R11: A counter step that falls in the same cycle as a decoded register write is dropped, and a line pulse in that cycle does not clear reload-pending. The prescaler still advances.
- R12: A write whose masked address matches none of the four registers has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_ce | input | 1 | CPU cycle enable, one per CPU cycle |
| line_pulse | input | 1 | One-cycle pulse at each video line |
| line_num | input | 9 | Number of the line flagged by line_pulse |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest path to reach from the ports is a latch, enable or acknowledge write that reloads the counter. This requires reload-pending to be set. In line mode, the flag is set only between an arm write, or a firing line, and the next line pulse. The random phase keeps latch values small so that lines fire often, and it sends writes often enough that they land inside that window. Directed sequences then cover the flag being cleared by a line with rendering off, the flag being set again by a firing line, and a write that collides with a line pulse.

// File: rtl/irq_down_timer_pkg.sv
package irq_down_timer_pkg;
   // One strobe per register, decoded from a single write.
   typedef struct packed {
      logic set_latch;
      logic arm;
      logic ack;
      logic enable;
   } reg_cmd_t;
endpackage

// File: rtl/irq_down_timer_decode.sv
module irq_down_timer_decode
   import irq_down_timer_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] DEC_MASK   = 16'hF003,
   parameter logic [ADDR_W-1:0] A_LATCH    = 16'hC000,
   parameter logic [ADDR_W-1:0] A_ARM      = 16'hC001,
   parameter logic [ADDR_W-1:0] A_ACK      = 16'hE000,
   parameter logic [ADDR_W-1:0] A_ENABLE   = 16'hE001
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output reg_cmd_t          cmd
);
   localparam int unsigned NREG = 4;

   initial begin
      assert ((A_LATCH & DEC_MASK) == A_LATCH && (A_ARM & DEC_MASK) == A_ARM &&
              (A_ACK & DEC_MASK) == A_ACK && (A_ENABLE & DEC_MASK) == A_ENABLE)
         else $error("register addresses must lie inside the decode mask");
      assert (A_LATCH != A_ARM && A_LATCH != A_ACK && A_LATCH != A_ENABLE &&
              A_ARM != A_ACK && A_ARM != A_ENABLE && A_ACK != A_ENABLE)
         else $error("register addresses must be distinct");
   end

   logic [ADDR_W-1:0] key;
   logic [NREG-1:0]   hit;
   logic [ADDR_W-1:0] targets [NREG];

   assign key        = wr_addr & DEC_MASK;
   assign targets[0] = A_ENABLE;
   assign targets[1] = A_ACK;
   assign targets[2] = A_ARM;
   assign targets[3] = A_LATCH;

   for (genvar g = 0; g < NREG; g++) begin : g_match
      assign hit[g] = wr_en && (key == targets[g]);
   end

   assign cmd = reg_cmd_t'(hit);
endmodule

// File: rtl/irq_down_timer_prescale.sv
module irq_down_timer_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic tick
);
   localparam int unsigned PW      = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit          IS_POW2 = ((DIV & (DIV - 1)) == 0);
   localparam logic [PW-1:0] LAST  = PW'(DIV - 1);

   initial begin
      assert (DIV >= 2) else $error("prescaler divide must be at least 2");
   end

   logic [PW-1:0] ph_q;

   if (IS_POW2) begin : g_pow2
      // Phase counter wraps by itself.
      assign tick = step && (ph_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ph_q <= '0;
         else if (step) ph_q <= ph_q + 1'b1;
      end
   end else begin : g_mod
      assign tick = step && (ph_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ph_q <= '0;
         else if (tick) ph_q <= '0;
         else if (step) ph_q <= ph_q + 1'b1;
      end
   end

   // R6: a tick always returns the phase to zero.
   p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (ph_q == '0));
endmodule

// File: rtl/irq_down_timer_core.sv
module irq_down_timer_core
   import irq_down_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned LINE_W = 9,
   parameter int unsigned LAST_LINE = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_cmd_t          cmd,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              cyc_tick,
   input  logic              line_pulse,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              mode_cyc,
   output logic              irq
);
   localparam int unsigned SW = CNT_W + 1;
   localparam logic [SW-1:0] ONE = SW'(1);

   initial begin
      assert (LAST_LINE < (1 << LINE_W)) else $error("LAST_LINE exceeds line number width");
      assert (CNT_W >= 1) else $error("counter width must be positive");
   end

   logic [CNT_W-1:0] latch_q;
   logic [SW-1:0]    cnt_q;     // two's complement, MSB is the sign
   logic             en_q, mode_q, pend_q, irq_q;
   logic             any_wr, line_tick, step, at_zero, is_neg;
   logic [SW-1:0]    reload_val;

   assign any_wr     = cmd.set_latch | cmd.arm | cmd.ack | cmd.enable;
   assign line_tick  = line_pulse && !mode_q && render_on &&
                       (line_num <= LINE_W'(LAST_LINE));
   assign step       = mode_q ? cyc_tick : line_tick;
   assign is_neg     = cnt_q[CNT_W];
   assign at_zero    = (cnt_q == '0);
   assign reload_val = {1'b0, latch_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         cnt_q   <= '0;
         en_q    <= 1'b0;
         mode_q  <= 1'b0;
         pend_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else if (any_wr) begin
         // Register writes win over steps in the same cycle.
         if (cmd.set_latch) begin
            latch_q <= wr_data;
            if (pend_q) cnt_q <= {1'b0, wr_data};
         end
         if (cmd.arm) begin
            pend_q <= 1'b1;
            cnt_q  <= reload_val;
            mode_q <= wr_data[0];
         end
         if (cmd.ack) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
            if (pend_q) cnt_q <= reload_val;
         end
         if (cmd.enable) begin
            en_q <= 1'b1;
            if (pend_q) cnt_q <= reload_val;
         end
      end else begin
         if (line_pulse && !mode_q) pend_q <= 1'b0;
         if (step && !is_neg) begin
            cnt_q <= cnt_q - ONE;
            if (at_zero && en_q) begin
               irq_q <= 1'b1;
               if (!mode_q) pend_q <= 1'b1;
            end
         end
      end
   end

   assign mode_cyc = mode_q;
   assign irq      = irq_q;

   // R4: acknowledge drops the request.
   p_ack_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.ack |=> !irq_q);

   // R10: the request holds until acknowledged.
   p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !cmd.ack) |=> irq_q);

   // R10: the request only rises while the interrupt is enabled.
   p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(en_q));

   // R9: without a reload the counter stays negative.
   p_stay_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_neg && !cmd.arm && !(pend_q && any_wr)) |=> cnt_q[CNT_W]);

   // R6: in cycle mode only prescaler ticks or writes move the counter.
   p_cyc_ignores_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !cyc_tick && !any_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_down_timer.sv
module irq_down_timer
   import irq_down_timer_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned LINE_W    = 9,
   parameter int unsigned LAST_LINE = 239,
   parameter int unsigned CYC_DIV   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              cpu_ce,
   input  logic              line_pulse,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              irq
);
   initial begin
      assert (ADDR_W >= 16) else $error("address must be at least 16 bits");
   end

   reg_cmd_t cmd;
   logic     mode_cyc, cyc_tick;

   irq_down_timer_decode #(
      .ADDR_W   (ADDR_W),
      .DEC_MASK (ADDR_W'(16'hF003)),
      .A_LATCH  (ADDR_W'(16'hC000)),
      .A_ARM    (ADDR_W'(16'hC001)),
      .A_ACK    (ADDR_W'(16'hE000)),
      .A_ENABLE (ADDR_W'(16'hE001))
   ) i_decode (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .cmd     (cmd)
   );

   irq_down_timer_prescale #(.DIV(CYC_DIV)) i_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (cpu_ce && mode_cyc),
      .tick  (cyc_tick)
   );

   irq_down_timer_core #(
      .CNT_W     (CNT_W),
      .LINE_W    (LINE_W),
      .LAST_LINE (LAST_LINE)
   ) i_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .wr_data    (wr_data),
      .cyc_tick   (cyc_tick),
      .line_pulse (line_pulse),
      .line_num   (line_num),
      .render_on  (render_on),
      .mode_cyc   (mode_cyc),
      .irq        (irq)
   );
endmodule

// File: tb/test_irq_down_timer.sv
module test_irq_down_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        cpu_ce = 1'b0;
   logic        line_pulse = 1'b0;
   logic [8:0]  line_num = '0;
   logic        render_on = 1'b0;
   logic        irq;

   int    n_chk = 0, n_fail = 0;
   string phase = "R1";
   bit    done = 1'b0;

   // Reference state
   int m_cnt, m_latch, m_pre;
   bit m_en, m_mode, m_pend, m_irq;

   always #10 clk = ~clk;

   irq_down_timer i_irq_down_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cpu_ce(cpu_ce), .line_pulse(line_pulse),
      .line_num(line_num), .render_on(render_on), .irq(irq));

   function automatic int decode(input logic w, input logic [15:0] a);
      logic [15:0] k;
      k = a & 16'hF003;
      if (!w) return 0;
      case (k)
         16'hC000: return 1;
         16'hC001: return 2;
         16'hE000: return 3;
         16'hE001: return 4;
         default:  return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_latch = 0; m_pre = 0;
         m_en = 0; m_mode = 0; m_pend = 0; m_irq = 0;
      end else begin
         int  op;
         bit  stp, pt;
         op = decode(wr_en, wr_addr);
         pt = m_mode && cpu_ce && (m_pre == 3);
         if (m_mode && cpu_ce) m_pre = (m_pre + 1) % 4;
         stp = m_mode ? pt : (line_pulse && render_on && line_num <= 239);
         case (op)
            1: begin m_latch = wr_data; if (m_pend) m_cnt = wr_data; end
            2: begin m_pend = 1; m_cnt = m_latch; m_mode = wr_data[0]; end
            3: begin m_en = 0; m_irq = 0; if (m_pend) m_cnt = m_latch; end
            4: begin m_en = 1; if (m_pend) m_cnt = m_latch; end
            default: begin
               bit old_mode;
               old_mode = m_mode;
               if (line_pulse && !old_mode) m_pend = 0;
               if (stp && m_cnt >= 0) begin
                  m_cnt = m_cnt - 1;
                  if (m_cnt < 0 && m_en) begin
                     m_irq = 1;
                     if (!old_mode) m_pend = 1;
                  end
               end
            end
         endcase
      end
   end

   // Continuous comparison against the reference.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (irq !== m_irq) begin
            n_fail++;
            $display("FAIL %s model irq=%0b exp=%0b at %0t", phase, irq, m_irq, $time);
         end
      end
   end

   task automatic drive(input logic w, input logic [15:0] a, input logic [7:0] d,
                        input logic ce, input logic lp, input logic [8:0] ln, input logic ro);
      @(negedge clk);
      wr_en = w; wr_addr = a; wr_data = d; cpu_ce = ce;
      line_pulse = lp; line_num = ln; render_on = ro;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      drive(1'b1, a, d, 1'b0, 1'b0, 9'd0, 1'b1);
   endtask

   task automatic line(input logic [8:0] n, input logic ro);
      drive(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, n, ro);
   endtask

   task automatic ce_pulse(input logic lp);
      drive(1'b0, 16'h0, 8'h0, 1'b1, lp, 9'd20, 1'b1);
   endtask

   task automatic expect_irq(input string tag, input logic e);
      drive(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 9'd0, 1'b0);
      n_chk++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s irq=%0b exp=%0b", tag, irq, e);
      end
   endtask

   task automatic do_reset();
      drive(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 9'd0, 1'b0);
      rst_n = 1'b0;
      drive(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 9'd0, 1'b0);
      rst_n = 1'b1;
   endtask

   initial begin
      #200000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      phase = "R1";
      expect_irq("R1 reset level", 1'b0);
      wr(16'hE001, 8'h00);
      line(9'd5, 1'b1);
      expect_irq("R1 zero counter fires on first line", 1'b1);
      repeat (5) line(9'd7, 1'b1);
      expect_irq("R10 level held", 1'b1);
      wr(16'hE002, 8'h00);
      expect_irq("R12 unmapped address ignored", 1'b1);
      wr(16'hE000, 8'h00);
      expect_irq("R4 ack clears", 1'b0);

      // Reload through arm, count 3 lines, fire on 4th
      phase = "R3";
      do_reset();
      wr(16'hC000, 8'd3);
      wr(16'hC001, 8'd0);
      wr(16'hE001, 8'd0);
      line(9'd240, 1'b1);
      line(9'd10, 1'b0);
      line(9'd0, 1'b1);
      line(9'd100, 1'b1);
      line(9'd239, 1'b1);
      expect_irq("R7 three counted lines no fire", 1'b0);
      repeat (3) ce_pulse(1'b0);
      expect_irq("R7 cpu_ce ignored in line mode", 1'b0);
      line(9'd1, 1'b1);
      expect_irq("R9 fire on 0 to -1", 1'b1);

      // Pending cleared by non-counted line; latch write then does not reload
      phase = "R2";
      do_reset();
      wr(16'hC000, 8'd5);
      wr(16'hC001, 8'd0);
      line(9'd3, 1'b0);
      wr(16'hC004, 8'd1);
      wr(16'hE001, 8'd0);
      repeat (5) line(9'd3, 1'b1);
      expect_irq("R8 pending cleared, latch write no reload", 1'b0);
      line(9'd3, 1'b1);
      expect_irq("R2 counter kept old value", 1'b1);
      do_reset();
      wr(16'hC000, 8'd5);
      wr(16'hC001, 8'd0);
      wr(16'hC000, 8'd1);
      wr(16'hE001, 8'd0);
      line(9'd3, 1'b1);
      expect_irq("R2 pending latch write reloads", 1'b0);
      line(9'd3, 1'b1);
      expect_irq("R2 fire after reload of 1", 1'b1);

      // Disabled reach of -1 stays there
      phase = "R9";
      do_reset();
      wr(16'hC001, 8'd0);
      line(9'd2, 1'b1);
      expect_irq("R10 disabled no fire", 1'b0);
      wr(16'hE001, 8'd0);
      repeat (4) line(9'd2, 1'b1);
      expect_irq("R9 stays at -1", 1'b0);

      // Cycle mode
      phase = "R6";
      do_reset();
      wr(16'hC000, 8'd2);
      wr(16'hC001, 8'd1);
      wr(16'hE001, 8'd0);
      for (int i = 0; i < 11; i++) ce_pulse(i[0]);
      expect_irq("R6 eleven cycles no fire", 1'b0);
      ce_pulse(1'b1);
      expect_irq("R6 twelfth cycle fires", 1'b1);
      wr(16'hE000, 8'd0);
      expect_irq("R4 ack in cycle mode", 1'b0);
      wr(16'hE001, 8'd0);
      for (int i = 0; i < 11; i++) ce_pulse(1'b0);
      expect_irq("R5 enable reloads while pending", 1'b0);
      ce_pulse(1'b0);
      expect_irq("R5 fire after reload", 1'b1);

      // Write colliding with a line pulse, then refire via pending set
      phase = "R11";
      do_reset();
      wr(16'hC000, 8'd1);
      wr(16'hC001, 8'd0);
      wr(16'hE001, 8'd0);
      drive(1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 9'd10, 1'b1);
      line(9'd10, 1'b1);
      expect_irq("R11 step dropped on write", 1'b0);
      line(9'd10, 1'b1);
      expect_irq("R11 fire one line later", 1'b1);
      phase = "R8";
      wr(16'hE000, 8'd0);
      wr(16'hE001, 8'd0);
      line(9'd10, 1'b1);
      expect_irq("R8 reload after fire", 1'b0);
      line(9'd10, 1'b1);
      expect_irq("R8 fire set pending again", 1'b1);

      // Random phase
      phase = "R12 random";
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         logic        w;
         case ($urandom_range(0, 7))
            0: a = 16'hC000;
            1: a = 16'hC001;
            2: a = 16'hE000;
            3: a = 16'hE001;
            4: a = 16'hC004;
            5: a = 16'hE005;
            6: a = 16'hA000;
            default: a = 16'hD001;
         endcase
         w = ($urandom_range(0, 5) == 0);
         d = 8'($urandom_range(0, 5));
         if (a[0] && $urandom_range(0, 3) != 0) d[0] = ($urandom_range(0, 2) == 0);
         drive(w, a, d, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
               9'($urandom_range(0, 261)), ($urandom_range(0, 5) != 0));
      end
      expect_irq("R12 random end", m_irq);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule